// File: doc/BRIEF.md
# Decoded Loop Replay Buffer

This block is a micro-op queue that sits between the decoders and rename. In normal operation it forwards each decoded micro-op to rename one cycle after it arrives. At the same time it records the incoming stream into a small buffer of at most 28 entries. When a short loop is found, the front end can stop, because the buffer itself supplies the loop body to rename.

A capture window opens on the first micro-op after an empty state. A loop is recognised when a taken backward branch jumps to the program counter of the first micro-op in the window and the whole body, branch included, fits in the buffer. The block then checks a second pass of the loop against what it stored. If that pass matches, the block switches to replay. During replay it issues the stored entries in order, one per cycle, wrapping back to the first entry after each pass. It also holds a front-end disable line high, so that prediction, fetch and decode can be powered down.

A flush or mispredict input ends replay at once and empties the buffer. Anything that rules out a loop abandons the current window. The causes are:
- a call or return marker on a non-branch micro-op,
- a backward branch to some other target,
- an oversized body,
- a mismatch during the second pass.

Top module: `lsd_buffer`

## Requirements
- R1: After reset, outValid, feDisable and loopActive are all low.
- R2: While feDisable is low and flush is low, outValid and outUop in cycle t+1 equal inValid and inUop of cycle t.
- R3: A valid micro-op with inBackBr=1 whose inTarget equals the program counter of the first micro-op of the open window, with a body of at most DEPTH entries, raises loopActive on the next cycle while feDisable stays low.
- R4: If the following pass presents the same program counters in the same order and closes with the same backward branch, feDisable rises on the cycle after that closing branch; feDisable is never high without loopActive.
- R5: While replaying, the block presents one valid entry every cycle in capture order, from the first micro-op to the closing branch, then wraps to the first.
- R6: While replaying, incoming micro-ops are ignored and never reach outUop.
- R7: A loop body of exactly DEPTH (28) entries is captured and replayed; a body of DEPTH+1 entries never raises loopActive.
- R8: When flush is high in cycle t, outValid, feDisable and loopActive are low in cycle t+1, and a later loop needs two passes again before replay. Flush wins over any other event in the same cycle.
- R9: A window that contains a non-branch micro-op with inCallRet=1 is abandoned, so a loop holding such a micro-op never raises loopActive.
- R10: During the second pass, a micro-op whose program counter differs from the stored entry drops loopActive on the next cycle, and replay does not start.
- R11: A backward branch whose target is not the window start closes the window, and a fresh window opens on the next valid micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Decoded micro-op present |
| inUop | input | UOP_W | Decoded micro-op payload |
| inPc | input | PC_W | Program counter of the micro-op |
| inBackBr | input | 1 | Micro-op is a taken backward branch |
| inTarget | input | PC_W | Branch target program counter |
| inCallRet | input | 1 | Micro-op is marked as call or return |
| flush | input | 1 | Mispredict or pipeline flush |
| outValid | output | 1 | Micro-op valid toward rename |
| outUop | output | UOP_W | Micro-op toward rename |
| feDisable | output | 1 | Front-end power-down request |
| loopActive | output | 1 | Loop detected (confirming or replaying) |

## Verification
Flush can arrive in the same cycle as the closing branch of the confirming pass, which would otherwise switch the block into replay. The bench drives both in one cycle and expects outValid, feDisable and loopActive low in the next cycle, and feDisable still low one cycle later. The bench also flushes while replay is wrapping, so that the wrap and the exit coincide, and then checks that a fresh loop needs two full passes before it replays.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [1:0] {
    ST_CAPTURE = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_STREAM  = 2'd2
  } lsd_state_e;

  typedef struct packed {
    logic wr;        // store current micro-op at wrIdx
    logic stream;    // drive output from buffer at rdIdx
    logic clearOut;  // squash output register
  } lsd_strobe_t;

endpackage

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int DEPTH = 28,
  parameter int PC_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PC_W-1:0]  inPc,
  input  logic             inBackBr,
  input  logic [PC_W-1:0]  inTarget,
  input  logic             inCallRet,
  input  logic             flush,
  input  logic             pcMatch,
  output lsd_strobe_t      strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             feDisable,
  output logic             loopActive
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  lsd_state_e       state, nState;
  logic [CNT_W-1:0] count, nCount;
  logic [CNT_W-1:0] len, nLen;
  logic [IDX_W-1:0] idx, nIdx;
  logic [PC_W-1:0]  startPc, nStartPc;

  logic             isLast;
  logic             closesWindow;
  logic [PC_W-1:0]  windowHead;

  assign isLast       = (CNT_W'(idx) == len - CNT_W'(1));
  assign windowHead   = (count == '0) ? inPc : startPc;
  assign closesWindow = inBackBr && (count < FULL) && (inTarget == windowHead);

  assign wrIdx = count[IDX_W-1:0];
  assign rdIdx = idx;

  always_comb begin
    nState   = state;
    nCount   = count;
    nLen     = len;
    nIdx     = idx;
    nStartPc = startPc;
    strb     = '0;
    if (flush) begin
      strb.clearOut = 1'b1;
      nState        = ST_CAPTURE;
      nCount        = '0;
      nIdx          = '0;
    end else begin
      unique case (state)
        ST_CAPTURE: begin
          if (inValid) begin
            if (inCallRet && !inBackBr) begin
              nCount = '0;
            end else if (inBackBr) begin
              if (closesWindow) begin
                strb.wr = 1'b1;
                nLen    = count + CNT_W'(1);
                nCount  = '0;
                nIdx    = '0;
                nState  = ST_CONFIRM;
                if (count == '0) nStartPc = inPc;
              end else begin
                nCount = '0;
              end
            end else if (count == FULL) begin
              nCount = '0;
            end else begin
              strb.wr = 1'b1;
              nCount  = count + CNT_W'(1);
              if (count == '0) nStartPc = inPc;
            end
          end
        end
        ST_CONFIRM: begin
          if (inValid) begin
            if (!pcMatch || (inCallRet && !inBackBr)) begin
              nState = ST_CAPTURE;
              nCount = '0;
            end else if (isLast) begin
              if (inBackBr && inTarget == startPc) begin
                nState = ST_STREAM;
                nIdx   = '0;
              end else begin
                nState = ST_CAPTURE;
                nCount = '0;
              end
            end else if (inBackBr) begin
              nState = ST_CAPTURE;
              nCount = '0;
            end else begin
              nIdx = idx + IDX_W'(1);
            end
          end
        end
        ST_STREAM: begin
          strb.stream = 1'b1;
          nIdx        = isLast ? '0 : idx + IDX_W'(1);
        end
        default: begin
          nState = ST_CAPTURE;
          nCount = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CAPTURE;
      count   <= '0;
      len     <= '0;
      idx     <= '0;
      startPc <= '0;
    end else begin
      state   <= nState;
      count   <= nCount;
      len     <= nLen;
      idx     <= nIdx;
      startPc <= nStartPc;
    end
  end

  assign feDisable  = (state == ST_STREAM);
  assign loopActive = (state != ST_CAPTURE);

endmodule

// File: rtl/lsd_data.sv
module lsd_data
  import lsd_pkg::*;
#(
  parameter int DEPTH = 28,
  parameter int UOP_W = 32,
  parameter int PC_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsd_strobe_t      strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             inValid,
  input  logic [UOP_W-1:0] inUop,
  input  logic [PC_W-1:0]  inPc,
  output logic             pcMatch,
  output logic             outValid,
  output logic [UOP_W-1:0] outUop
);

  logic [UOP_W-1:0] uopMem [DEPTH];
  logic [PC_W-1:0]  pcMem  [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wr) begin
      uopMem[wrIdx] <= inUop;
      pcMem[wrIdx]  <= inPc;
    end
  end

  assign pcMatch = (pcMem[rdIdx] == inPc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outUop   <= '0;
    end else if (strb.clearOut) begin
      outValid <= 1'b0;
    end else if (strb.stream) begin
      outValid <= 1'b1;
      outUop   <= uopMem[rdIdx];
    end else begin
      outValid <= inValid;
      outUop   <= inUop;
    end
  end

endmodule

// File: rtl/lsd_buffer.sv
module lsd_buffer
  import lsd_pkg::*;
#(
  parameter int UOP_W = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [UOP_W-1:0] inUop,
  input  logic [PC_W-1:0]  inPc,
  input  logic             inBackBr,
  input  logic [PC_W-1:0]  inTarget,
  input  logic             inCallRet,
  input  logic             flush,
  output logic             outValid,
  output logic [UOP_W-1:0] outUop,
  output logic             feDisable,
  output logic             loopActive
);

  localparam int IDX_W = $clog2(DEPTH);

  lsd_strobe_t      strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             pcMatch;

  lsd_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inPc(inPc), .inBackBr(inBackBr),
    .inTarget(inTarget), .inCallRet(inCallRet), .flush(flush),
    .pcMatch(pcMatch), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .feDisable(feDisable), .loopActive(loopActive)
  );

  lsd_data #(.DEPTH(DEPTH), .UOP_W(UOP_W), .PC_W(PC_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .inValid(inValid), .inUop(inUop), .inPc(inPc),
    .pcMatch(pcMatch), .outValid(outValid), .outUop(outUop)
  );

endmodule

// File: rtl/lsd_buffer_chk.sv
module lsd_buffer_chk #(
  parameter int UOP_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [UOP_W-1:0] inUop,
  input logic             flush,
  input logic             outValid,
  input logic [UOP_W-1:0] outUop,
  input logic             feDisable,
  input logic             loopActive
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_FE_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    feDisable |-> loopActive); // R4

  AST_STREAM_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rstN)
    armed && $rose(feDisable) |-> $past(loopActive)); // R4

  AST_DETECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    armed && $rose(loopActive) |-> !feDisable); // R3

  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!feDisable && !loopActive && !outValid)); // R8

  AST_STREAM_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (feDisable && !flush) |=> outValid); // R5

  AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !feDisable && !flush) |=> (outValid == $past(inValid))); // R2

  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !feDisable && !flush && inValid) |=> (outUop == $past(inUop))); // R2

endmodule

bind lsd_buffer lsd_buffer_chk #(.UOP_W(UOP_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inUop(inUop), .flush(flush),
  .outValid(outValid), .outUop(outUop), .feDisable(feDisable),
  .loopActive(loopActive)
);

// File: tb/lsd_buffer_bench.sv
`timescale 1ns/1ps
module lsd_buffer_bench;

  localparam int UOP_W = 32;
  localparam int PC_W  = 16;
  localparam int DEPTH = 28;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [UOP_W-1:0] inUop = '0;
  logic [PC_W-1:0]  inPc = '0;
  logic             inBackBr = 1'b0;
  logic [PC_W-1:0]  inTarget = '0;
  logic             inCallRet = 1'b0;
  logic             flush = 1'b0;
  logic             outValid;
  logic [UOP_W-1:0] outUop;
  logic             feDisable;
  logic             loopActive;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lsd_buffer #(.UOP_W(UOP_W), .PC_W(PC_W), .DEPTH(DEPTH)) u_lsd_buffer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inUop(inUop), .inPc(inPc),
    .inBackBr(inBackBr), .inTarget(inTarget), .inCallRet(inCallRet),
    .flush(flush), .outValid(outValid), .outUop(outUop),
    .feDisable(feDisable), .loopActive(loopActive)
  );

  function automatic logic [UOP_W-1:0] mkUop(input logic [PC_W-1:0] pc);
    return 32'hC0DE_0000 | UOP_W'(pc);
  endfunction

  task automatic chk(input string tag, input logic [UOP_W-1:0] act,
                     input logic [UOP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [PC_W-1:0] pc, input logic bb,
                      input logic [PC_W-1:0] tgt, input logic cr, input logic fl);
    inValid   = v;
    inPc      = pc;
    inUop     = mkUop(pc);
    inBackBr  = bb;
    inTarget  = tgt;
    inCallRet = cr;
    flush     = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic doFlush();
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
  endtask

  // feed `iters` passes of a loop of n micro-ops starting at base; the
  // micro-op at offset crOff carries a call/return marker (crOff >= n: none)
  task automatic feedLoop(input int base, input int n, input int iters,
                          input int crOff, output logic sawLa, output logic sawFe);
    sawLa = 1'b0;
    sawFe = 1'b0;
    for (int it = 0; it < iters; it++) begin
      for (int k = 0; k < n; k++) begin
        step(1'b1, PC_W'(base + k), (k == n - 1), PC_W'(base), (k == crOff), 1'b0);
        sawLa |= loopActive;
        sawFe |= feDisable;
      end
    end
  endtask

  typedef struct packed {
    logic            v;
    logic [PC_W-1:0] pc;
    logic            bb;
    logic [PC_W-1:0] tgt;
    logic            fl;
    logic            eov;
    logic [PC_W-1:0] epc;
    logic            efe;
    logic            ela;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'd5,  1'b0, 16'd0,  1'b0, 1'b1, 16'd5,  1'b0, 1'b0},
    '{1'b1, 16'd10, 1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b0, 1'b0},
    '{1'b1, 16'd11, 1'b0, 16'd0,  1'b0, 1'b1, 16'd11, 1'b0, 1'b0},
    '{1'b1, 16'd12, 1'b1, 16'd10, 1'b0, 1'b1, 16'd12, 1'b0, 1'b0},
    '{1'b1, 16'd10, 1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b0, 1'b0},
    '{1'b1, 16'd11, 1'b0, 16'd0,  1'b0, 1'b1, 16'd11, 1'b0, 1'b0},
    '{1'b1, 16'd12, 1'b1, 16'd10, 1'b0, 1'b1, 16'd12, 1'b0, 1'b1},
    '{1'b1, 16'd10, 1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b0, 1'b1},
    '{1'b1, 16'd11, 1'b0, 16'd0,  1'b0, 1'b1, 16'd11, 1'b0, 1'b1},
    '{1'b1, 16'd12, 1'b1, 16'd10, 1'b0, 1'b1, 16'd12, 1'b1, 1'b1},
    '{1'b1, 16'd99, 1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b1, 1'b1},
    '{1'b0, 16'd0,  1'b0, 16'd0,  1'b0, 1'b1, 16'd11, 1'b1, 1'b1},
    '{1'b1, 16'd98, 1'b0, 16'd0,  1'b0, 1'b1, 16'd12, 1'b1, 1'b1},
    '{1'b0, 16'd0,  1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b1, 1'b1},
    '{1'b0, 16'd0,  1'b0, 16'd0,  1'b1, 1'b0, 16'd0,  1'b0, 1'b0},
    '{1'b1, 16'd10, 1'b0, 16'd0,  1'b0, 1'b1, 16'd10, 1'b0, 1'b0}
  };

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishUp();
  end

  initial begin
    logic la, fe;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outValid after reset", UOP_W'(outValid), '0);
    chk("R1 feDisable after reset", UOP_W'(feDisable), '0);
    chk("R1 loopActive after reset", UOP_W'(loopActive), '0);
    rstN = 1'b1;
    idle();

    // table: R2 pass-through, R11 restart, R3 detect, R4 confirm,
    // R5 replay order with wrap, R6 inputs ignored, R8 flush
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].v, VEC[i].pc, VEC[i].bb, VEC[i].tgt, 1'b0, VEC[i].fl);
      chk($sformatf("R2/R5/R8 row %0d outValid", i), UOP_W'(outValid), UOP_W'(VEC[i].eov));
      if (VEC[i].eov)
        chk($sformatf("R2/R5/R6 row %0d outUop", i), outUop, mkUop(VEC[i].epc));
      chk($sformatf("R4/R8 row %0d feDisable", i), UOP_W'(feDisable), UOP_W'(VEC[i].efe));
      chk($sformatf("R3/R11 row %0d loopActive", i), UOP_W'(loopActive), UOP_W'(VEC[i].ela));
    end

    // R7: exactly DEPTH entries is captured and replayed
    doFlush();
    feedLoop(100, DEPTH, 2, DEPTH, la, fe);
    chk("R7 full-size loop feDisable", UOP_W'(feDisable), 1);
    for (int k = 0; k < DEPTH + 2; k++) begin
      idle();
      chk($sformatf("R7 full-size replay %0d", k), outUop, mkUop(PC_W'(100 + (k % DEPTH))));
    end
    doFlush();
    // R7: DEPTH+1 entries never captured
    feedLoop(200, DEPTH + 1, 3, DEPTH + 1, la, fe);
    chk("R7 oversized loop loopActive seen", UOP_W'(la), '0);
    chk("R7 oversized loop feDisable seen", UOP_W'(fe), '0);

    // R9: call/return marker inside the body blocks capture
    doFlush();
    feedLoop(300, 4, 3, 1, la, fe);
    chk("R9 call-marked loop loopActive seen", UOP_W'(la), '0);

    // R10: mismatching second pass
    doFlush();
    feedLoop(400, 3, 1, 3, la, fe);
    chk("R10 first pass loopActive", UOP_W'(loopActive), 1);
    step(1'b1, 16'd400, 1'b0, 16'd0, 1'b0, 1'b0);
    step(1'b1, 16'd405, 1'b0, 16'd0, 1'b0, 1'b0);
    chk("R10 mismatch drops loopActive", UOP_W'(loopActive), '0);
    chk("R10 mismatch feDisable", UOP_W'(feDisable), '0);
    step(1'b1, 16'd402, 1'b1, 16'd400, 1'b0, 1'b0);
    chk("R10 no replay after mismatch", UOP_W'(feDisable), '0);

    // R8: flush together with the closing branch of the confirming pass
    doFlush();
    feedLoop(500, 3, 1, 3, la, fe);
    step(1'b1, 16'd500, 1'b0, 16'd0, 1'b0, 1'b0);
    step(1'b1, 16'd501, 1'b0, 16'd0, 1'b0, 1'b0);
    step(1'b1, 16'd502, 1'b1, 16'd500, 1'b0, 1'b1);
    chk("R8 same-cycle flush outValid", UOP_W'(outValid), '0);
    chk("R8 same-cycle flush loopActive", UOP_W'(loopActive), '0);
    idle();
    chk("R8 same-cycle flush feDisable stays low", UOP_W'(feDisable), '0);

    // R8: flush during replay wrap, then a new loop needs two passes
    feedLoop(600, 2, 2, 2, la, fe);
    chk("R4 two-entry loop replays", UOP_W'(feDisable), 1);
    idle();
    idle();
    doFlush();
    chk("R8 flush in replay feDisable", UOP_W'(feDisable), '0);
    feedLoop(600, 2, 1, 2, la, fe);
    chk("R8 one pass after flush no replay", UOP_W'(feDisable), '0);
    feedLoop(600, 2, 1, 2, la, fe);
    chk("R8 second pass after flush replays", UOP_W'(feDisable), 1);
    idle();
    chk("R5 replay after re-capture", outUop, mkUop(16'd600));

    finishUp();
  end

endmodule